// File: doc/BRIEF.md
# Watchdog Timer with Enable-Gated Down-Counter

This block is a watchdog timer behind an APB slave port. Software programs a reload value, and a down-counter then steps once for each pulse of a separate count strobe `tick_i`. The counter runs only while the run-enable bit of the control register is set. That same bit also unmasks the interrupt. When the count is exhausted, a sticky raw status bit sets and the counter starts over from the reload value. Writing any value to the acknowledge register clears the status and restarts the count.

A rising edge of the enable bit, or a write to the reload register, restarts the count from the reload value, so software always starts from a known count. A build-time parameter selects a locking variant: once the enable bit is set, it ignores every further control write until reset.

Top module: `wdt_apb`

## Requirements
- R1: After reset the reload register and the count register both read 0xFFFFFFFF, and the control register, the raw status and `irq_o` are all 0.
- R2: While the enable bit (control offset 0x08, bit 0) is 0, the count does not change, except through a reload write or an acknowledge write.
- R3: A write to the reload register (offset 0x00) sets both the reload register and the count to the written value in the same cycle, whether the counter is enabled or not.
- R4: A control write that takes the enable bit from 0 to 1 loads the count from the reload register.
- R5: While enabled, the count (offset 0x04, read-only) drops by exactly one for each cycle in which `tick_i` is high. For example, a load of 4000 followed by 500 ticks reads 3500.
- R6: A tick while enabled with a count of 0 sets the raw status (offset 0x10, bit 0) and reloads the count from the reload register. `irq_o` is the raw status ANDed with the enable bit.
- R7: The raw status does not set while the count is nonzero, including at a count of 1.
- R8: Clearing the enable bit freezes the count at its present value and leaves the raw status unchanged.
- R9: Any write to the acknowledge register (offset 0x0C, write-only, reads 0) clears the raw status and reloads the count.
- R10: With `LOCK_EN`=1, once the enable bit is 1, control writes are ignored: the bit reads back 1 and counting continues until reset. With `LOCK_EN`=0, the enable bit follows each control write.
- R11: Reset stops a running counter and restores the default reload and count values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) / read (0) |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | CNT_W | Write data |
| prdata_o | output | CNT_W | Read data, valid while selected for a read |
| tick_i | input | 1 | Count strobe, one step per high cycle |
| irq_o | output | 1 | Interrupt, raw status gated by enable |

## Verification
The hardest situations to reach are exhaustion of the count, and collisions between ticks and register writes: a tick in the same cycle as an enable rise, an acknowledge or a reload write. Long directed runs cover the large literal counts. The random phase writes small reload values (0 to 24) while ticks arrive at random. This makes zero crossings, reloads and acknowledge races frequent, and two instances, one locking and one not, see the same bus traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFF_LOAD = 32'h00;
  localparam int unsigned OFF_CNT  = 32'h04;
  localparam int unsigned OFF_CTRL = 32'h08;
  localparam int unsigned OFF_ACK  = 32'h0C;
  localparam int unsigned OFF_STAT = 32'h10;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif import wdt_pkg::*; #(
  parameter int unsigned     CNT_W    = 32,
  parameter int unsigned     ADDR_W   = 5,
  parameter bit              LOCK_EN  = 1'b0,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [CNT_W-1:0]  pwdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  output logic [CNT_W-1:0]  prdata_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              en_o,
  output logic              ld_we_o,
  output logic              ack_we_o,
  output logic              en_rise_o
);
  logic wr_acc;
  logic sel_load, sel_cnt, sel_ctrl, sel_ack, sel_stat;
  logic ctrl_take;
  logic [CNT_W-1:0] load_q;
  logic en_q;

  assign wr_acc   = psel_i & penable_i & pwrite_i;
  assign sel_load = (paddr_i == ADDR_W'(OFF_LOAD));
  assign sel_cnt  = (paddr_i == ADDR_W'(OFF_CNT));
  assign sel_ctrl = (paddr_i == ADDR_W'(OFF_CTRL));
  assign sel_ack  = (paddr_i == ADDR_W'(OFF_ACK));
  assign sel_stat = (paddr_i == ADDR_W'(OFF_STAT));

  generate
    if (LOCK_EN) begin : g_lock
      assign ctrl_take = wr_acc & sel_ctrl & ~en_q;
    end else begin : g_free
      assign ctrl_take = wr_acc & sel_ctrl;
    end
  endgenerate

  assign ld_we_o   = wr_acc & sel_load;
  assign ack_we_o  = wr_acc & sel_ack;
  assign en_rise_o = ctrl_take & pwdata_i[0] & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= LOAD_RST;
      en_q   <= 1'b0;
    end else begin
      if (ld_we_o)   load_q <= pwdata_i;
      if (ctrl_take) en_q   <= pwdata_i[0];
    end
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      if (sel_load)      prdata_o = load_q;
      else if (sel_cnt)  prdata_o = cnt_i;
      else if (sel_ctrl) prdata_o = CNT_W'(en_q);
      else if (sel_stat) prdata_o = CNT_W'(raw_i);
    end
  end

  assign load_o = load_q;
  assign en_o   = en_q;

  generate
    if (LOCK_EN) begin : g_lock_chk
      // R10
      en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |=> en_q);
    end
  endgenerate

  // R3
  load_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |=> load_q == $past(pwdata_i));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned      CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             ld_we_i,
  input  logic             ack_we_i,
  input  logic             en_rise_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             raw_o
);
  logic [CNT_W-1:0] cnt_q;
  logic raw_q;
  logic step, expire;

  assign step   = en_i & tick_i;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_RST;
      raw_q <= 1'b0;
    end else if (ld_we_i) begin
      cnt_q <= wdata_i;
    end else if (ack_we_i) begin
      cnt_q <= load_i;
      raw_q <= 1'b0;
    end else if (en_rise_i) begin
      cnt_q <= load_i;
    end else if (expire) begin
      cnt_q <= load_i;
      raw_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign raw_o = raw_q;

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_we_i && !ack_we_i && !en_rise_i) |=> $stable(cnt_q));
  // R5
  one_per_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q != '0 && !ld_we_i && !ack_we_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  rise_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rise_i && !ld_we_i) |=> cnt_q == $past(load_i));
  // R6
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q == '0 && !ld_we_i && !ack_we_i) |=> raw_q && cnt_q == $past(load_i));
  // R7
  no_early_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !ack_we_i) |=> raw_q == $past(raw_q));
  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !ld_we_i) |=> !raw_q && cnt_q == $past(load_i));
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb #(
  parameter int unsigned      CNT_W    = 32,
  parameter int unsigned      ADDR_W   = 5,
  parameter bit               LOCK_EN  = 1'b0,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [CNT_W-1:0]  pwdata_i,
  output logic [CNT_W-1:0]  prdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt, load;
  logic raw, en, ld_we, ack_we, en_rise;

  wdt_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LOCK_EN(LOCK_EN), .LOAD_RST(LOAD_RST)) regif_i (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .cnt_i(cnt), .raw_i(raw), .prdata_o,
    .load_o(load), .en_o(en), .ld_we_o(ld_we), .ack_we_o(ack_we), .en_rise_o(en_rise)
  );

  wdt_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) cnt_i (
    .clk_i, .rst_ni, .tick_i, .en_i(en), .ld_we_i(ld_we), .ack_we_i(ack_we),
    .en_rise_i(en_rise), .wdata_i(pwdata_i), .load_i(load), .cnt_o(cnt), .raw_o(raw)
  );

  assign irq_o = raw & en;

  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ld_we && !ack_we && !en_rise) |=> $stable(cnt) && $stable(raw));
endmodule

// File: tb/wdt_apb_tb_top.sv
`timescale 1ns/1ps
module wdt_apb_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic tick_rand = 1'b0, tick_on = 1'b0, rnd_bit = 1'b0;
  logic tick_i;
  logic [31:0] prdata [2];
  logic irq [2];
  int n_chk = 0, n_fail = 0;

  logic [31:0] m_load [2];
  logic [31:0] m_cnt [2];
  logic m_en [2];
  logic m_raw [2];

  always #2 clk_i = ~clk_i;
  always @(negedge clk_i) rnd_bit <= 1'($urandom_range(0, 1));
  assign tick_i = tick_rand ? rnd_bit : tick_on;

  wdt_apb #(.LOCK_EN(1'b0)) dut_i (
    .clk_i, .rst_ni, .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata[0]), .tick_i, .irq_o(irq[0]));
  wdt_apb #(.LOCK_EN(1'b1)) dut_lock_i (
    .clk_i, .rst_ni, .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata[1]), .tick_i, .irq_o(irq[1]));

  // reference model built from the requirements
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < 2; v++) begin
        m_load[v] <= '1; m_cnt[v] <= '1; m_en[v] <= 1'b0; m_raw[v] <= 1'b0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        logic wr, take, rise;
        wr   = psel && penable && pwrite;
        take = wr && paddr == 5'h08 && !(v == 1 && m_en[v]);
        rise = take && pwdata[0] && !m_en[v];
        if (take) m_en[v] <= pwdata[0];
        if (wr && paddr == 5'h00) begin
          m_load[v] <= pwdata; m_cnt[v] <= pwdata;
        end else if (wr && paddr == 5'h0C) begin
          m_raw[v] <= 1'b0; m_cnt[v] <= m_load[v];
        end else if (rise) begin
          m_cnt[v] <= m_load[v];
        end else if (m_en[v] && tick_i) begin
          if (m_cnt[v] == 0) begin m_raw[v] <= 1'b1; m_cnt[v] <= m_load[v]; end
          else m_cnt[v] <= m_cnt[v] - 1;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(int v, logic [4:0] a);
    case (a)
      5'h00: return m_load[v];
      5'h04: return m_cnt[v];
      5'h08: return {31'b0, m_en[v]};
      5'h10: return {31'b0, m_raw[v]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk_i); penable = 1;
    @(negedge clk_i); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [4:0] a, string tag, output logic [31:0] d0);
    @(negedge clk_i); psel = 1; penable = 0; pwrite = 0; paddr = a;
    #1;
    for (int v = 0; v < 2; v++) begin
      chk(tag, prdata[v], exp_rd(v, a));
      chk("R6", 32'(irq[v]), 32'(m_raw[v] & m_en[v]));
    end
    d0 = prdata[0];
    @(negedge clk_i); penable = 1;
    @(negedge clk_i); psel = 0; penable = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk_i); tick_on = 1;
    repeat (n) @(negedge clk_i);
    tick_on = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    repeat (2) @(negedge clk_i); rst_ni = 1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i); rst_ni = 1;
    // R1 defaults
    rd(5'h00, "R1", d); chk("R1", d, 32'hFFFF_FFFF);
    rd(5'h04, "R1", d); chk("R1", d, 32'hFFFF_FFFF);
    rd(5'h08, "R1", d); chk("R1", d, 0);
    rd(5'h10, "R1", d); chk("R1", d, 0);
    // R2 disabled out of reset
    ticks(50); rd(5'h04, "R2", d); chk("R2", d, 32'hFFFF_FFFF);
    // R3 load while disabled
    wr(5'h00, 4000); rd(5'h04, "R3", d); chk("R3", d, 4000);
    ticks(30); rd(5'h04, "R2", d); chk("R2", d, 4000);
    // R5 count
    wr(5'h08, 1); ticks(500); rd(5'h04, "R5", d); chk("R5", d, 3500);
    // R8 freeze (lock instance keeps running: R10)
    wr(5'h08, 0); ticks(100); rd(5'h04, "R8", d); chk("R8", d, 3500);
    rd(5'h08, "R10", d); chk("R10", d, 0);
    // R4 enable rise reloads
    wr(5'h08, 1); rd(5'h04, "R4", d); chk("R4", d, 4000);
    ticks(50); rd(5'h04, "R5", d); chk("R5", d, 3950);
    // R3 load while running, R7 raw stays 0 at count 1
    wr(5'h00, 5000); rd(5'h04, "R3", d); chk("R3", d, 5000);
    ticks(4999); rd(5'h04, "R7", d); chk("R7", d, 1);
    rd(5'h10, "R7", d); chk("R7", d, 0);
    ticks(1); rd(5'h10, "R7", d); chk("R7", d, 0);
    // R6 expiry
    ticks(1); rd(5'h10, "R6", d); chk("R6", d, 1);
    rd(5'h04, "R6", d); chk("R6", d, 5000);
    // R9 acknowledge
    ticks(7); wr(5'h0C, 0); rd(5'h10, "R9", d); chk("R9", d, 0);
    rd(5'h04, "R9", d); chk("R9", d, 5000);
    rd(5'h0C, "R9", d); chk("R9", d, 0);
    // R11 reset stops counter
    do_reset();
    rd(5'h00, "R11", d); chk("R11", d, 32'hFFFF_FFFF);
    ticks(100); rd(5'h04, "R11", d); chk("R11", d, 32'hFFFF_FFFF);
    rd(5'h08, "R11", d); chk("R11", d, 0);
    // random phase
    tick_rand = 1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (i == 2000) do_reset();
      case (r)
        0, 1: wr(5'h00, 32'($urandom_range(0, 24)));
        2, 3: wr(5'h08, {31'b0, $urandom_range(0, 3) != 0});
        4:    wr(5'h0C, $urandom);
        default: begin
          int k;
          k = $urandom_range(0, 4);
          case (k)
            0: rd(5'h00, "R3", d);
            1: rd(5'h04, "R5", d);
            2: rd(5'h08, "R10", d);
            3: rd(5'h0C, "R9", d);
            default: rd(5'h10, "R6", d);
          endcase
        end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule